// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with Cascade Support

This block gathers eight interrupt request lines, holds them in a pending register, and resolves them by fixed priority against a mask and an in-service register. It signals one interrupt output to the processor. It answers a two-pulse acknowledge handshake by moving the winning line into service and then placing a vector on the read data bus. Software reaches it through two addresses, even and odd, selected by one address bit. The block is set up with a short series of setup words whose number depends on the first word. After setup, command words written to the even address handle end-of-interrupt, a special mask mode, polling and the choice of status register for even-address reads.

Several controllers can be chained. A master is told which of its lines have a slave behind them. When such a line is acknowledged, the master drives the line number on a cascade output and leaves the vector to the slave. A slave is told its own identity and answers acknowledge pulses only when the cascade input carries that identity. Bus timing between separate parts is not modelled.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An even-address write with data bit 4 set starts setup. In that word, bit 3 = 1 selects level capture (0 selects edge), bit 1 = 1 selects single operation (0 selects cascade), and bit 0 = 1 announces a last setup word. The next odd-address write is the vector base. In cascade operation the following odd write is the cascade word. If announced, the last word comes next. Only after that does an odd write load the mask.
- R2: After reset and after each setup start, the mask reads 0xFF, the in-service and pending registers are cleared, and even-address reads return the pending register.
- R3: Odd-address reads return the mask. A mask bit of 1 keeps that line from raising irq_out, but the line is still recorded in the pending register.
- R4: An even write with bits 4:3 = 01 is a status command. Bits 1:0 = 10 select the pending register for even reads, 11 select the in-service register, and 0x leave the choice unchanged.
- R5: Line 0 has the highest priority and line 7 the lowest. irq_out is high when an unmasked pending line has a lower index than every in-service line.
- R6: When bit 4 of the last setup word is set (nested mode), a pending line that is itself the highest in-service line may also raise irq_out.
- R7: In a status command, bits 6:5 = 11 enter special mask mode and 10 leave it. In this mode any unmasked pending line that is not in service raises irq_out.
- R8: The first acknowledge pulse moves the winning line from pending to in service. During the second pulse, rd_data equals the vector base plus the line number. With no winner, line 7 is used and no in-service bit is set.
- R9: When bit 1 of the last setup word is set, the acknowledged line leaves service at the end of the second pulse.
- R10: An even write with bits 4:3 = 00 and bit 5 = 1 ends an interrupt. With bit 6 = 0 it clears the lowest-index in-service bit. With bit 6 = 1 it clears the in-service bit named by bits 2:0. With bit 5 = 0 the write has no effect.
- R11: In edge capture, a line is latched on a rising input and held until acknowledged. In level capture, the pending bit follows the input one cycle later.
- R12: A status command with bit 2 set arms a poll. The next even-address read strobe returns bit 7 = request present and bits 2:0 = winning line, and moves that line into service.
- R13: A cascade master, which is the default role or is chosen by last-word bits 3:2 = 11, takes the cascade word as a line mask. During the second acknowledge of a masked line it raises cas_oe, drives cas_out with the line number, and returns 0 on rd_data.
- R14: A cascade slave, chosen by last-word bits 3:2 = 10, takes its identity from cascade-word bits 2:0. It ignores acknowledge pulses unless cas_in equals that identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe (consumes an armed poll) |
| addr_odd | input | 1 | Address select: 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, or the vector during the second acknowledge |
| req_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |
| ack_in | input | 1 | Acknowledge pulse, one cycle per pulse |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_oe | output | 1 | Cascade output valid |

## Verification
The bench checks that a single-mode setup skips the cascade word. A design that always waits for that word would swallow the first mask write and leave every line masked. It checks that an in-service line blocks lower lines but not higher ones, and that nested mode readmits the same line. Getting either wrong would either hide the next interrupt or let nesting run away. It also covers the spurious vector on an empty acknowledge, a write with the end-of-interrupt flag clear, and a slave acknowledged under a foreign identity. Each of these should leave the in-service register untouched, so a wrong design would show a changed ISR readback.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NL = 8;
    localparam int LW = $clog2(NL);
    localparam int DW = 8;

    typedef enum logic [1:0] {
        INIT_DONE,
        INIT_W2,
        INIT_W3,
        INIT_W4
    } init_st_e;

    typedef struct packed {
        logic          level_mode;
        logic          single_mode;
        logic          sfnm;
        logic          aeoi;
        logic          master;
        logic [DW-1:0] vec_base;
        logic [DW-1:0] cas_word;
    } ctrl_cfg_t;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] idx;
    } pick_t;

    // lowest set index wins
    function automatic pick_t pick_lowest(input logic [NL-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = LW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [NL-1:0] onehot(input logic [LW-1:0] idx);
        return NL'(1) << idx;
    endfunction

    // lines allowed past the in-service barrier
    function automatic logic [NL-1:0] pass_mask(input logic [NL-1:0] isr,
                                                input logic nest);
        logic [NL-1:0] m;
        for (int i = 0; i < NL; i++) begin
            logic blk;
            blk = nest ? 1'b0 : isr[i];
            for (int j = 0; j < i; j++) blk = blk | isr[j];
            m[i] = ~blk;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          addr_odd,
    input  logic [DW-1:0] wr_data,
    output ctrl_cfg_t     cfg,
    output logic [NL-1:0] imr,
    output logic          sel_isr,
    output logic          smm,
    output logic          poll_req,
    output logic          eoi_ns,
    output logic          eoi_sp,
    output logic [LW-1:0] eoi_line,
    output logic          init_clr
);

    init_st_e st;
    logic     need_w4;
    logic     even_wr, odd_wr, ocw3_wr, ocw2_wr;

    assign even_wr  = wr_en & ~addr_odd;
    assign odd_wr   = wr_en & addr_odd;
    assign init_clr = even_wr & wr_data[4];
    assign ocw3_wr  = even_wr & (st == INIT_DONE) & (wr_data[4:3] == 2'b01);
    assign ocw2_wr  = even_wr & (st == INIT_DONE) & (wr_data[4:3] == 2'b00);

    assign poll_req = ocw3_wr & wr_data[2];
    assign eoi_ns   = ocw2_wr & wr_data[5] & ~wr_data[6];
    assign eoi_sp   = ocw2_wr & wr_data[5] & wr_data[6];
    assign eoi_line = wr_data[LW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= INIT_DONE;
            need_w4 <= 1'b0;
            cfg     <= '{level_mode: 1'b0, single_mode: 1'b1, sfnm: 1'b0,
                         aeoi: 1'b0, master: 1'b1, vec_base: '0, cas_word: '0};
            imr     <= '1;
            sel_isr <= 1'b0;
            smm     <= 1'b0;
        end else if (init_clr) begin
            st              <= INIT_W2;
            cfg.level_mode  <= wr_data[3];
            cfg.single_mode <= wr_data[1];
            need_w4         <= wr_data[0];
            cfg.sfnm        <= 1'b0;
            cfg.aeoi        <= 1'b0;
            cfg.master      <= 1'b1;
            imr             <= '1;
            sel_isr         <= 1'b0;
            smm             <= 1'b0;
        end else if (odd_wr) begin
            unique case (st)
                INIT_W2: begin
                    cfg.vec_base <= wr_data;
                    st <= !cfg.single_mode ? INIT_W3 :
                          (need_w4 ? INIT_W4 : INIT_DONE);
                end
                INIT_W3: begin
                    cfg.cas_word <= wr_data;
                    st <= need_w4 ? INIT_W4 : INIT_DONE;
                end
                INIT_W4: begin
                    cfg.sfnm   <= wr_data[4];
                    cfg.aeoi   <= wr_data[1];
                    cfg.master <= wr_data[3] ? wr_data[2] : 1'b1;
                    st         <= INIT_DONE;
                end
                default: imr <= wr_data;
            endcase
        end else if (ocw3_wr) begin
            if (wr_data[6]) smm <= wr_data[5];
            if (wr_data[1]) sel_isr <= wr_data[0];
        end
    end

    AST_INIT_MASKS_ALL: assert property (@(posedge clk) disable iff (rst)
        init_clr |=> (imr == '1) && !sel_isr && !smm); // R2

    AST_SINGLE_SKIPS_W3: assert property (@(posedge clk) disable iff (rst)
        (odd_wr && !init_clr && st == INIT_W2 && cfg.single_mode && !need_w4)
        |=> st == INIT_DONE); // R1

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          level_mode,
    input  logic          flush,
    input  logic [NL-1:0] req_in,
    input  logic [NL-1:0] clr_lines,
    output logic [NL-1:0] irr
);

    logic [NL-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            irr   <= '0;
        end else begin
            req_q <= req_in;
            if (flush)
                irr <= '0;
            else if (level_mode)
                irr <= req_in & ~clr_lines;
            else
                irr <= (irr | (req_in & ~req_q)) & ~clr_lines;
        end
    end

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && !flush)
        |=> (($past(irr) & ~$past(clr_lines) & ~irr) == '0)); // R11

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (level_mode && !flush) |=> ((irr & ~$past(req_in)) == '0)); // R11

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_ctrl_pkg::*;
(
    input  logic [NL-1:0] irr,
    input  logic [NL-1:0] isr,
    input  logic [NL-1:0] imr,
    input  logic          nest,
    input  logic          smm,
    output logic          irq,
    output pick_t         win
);

    logic [NL-1:0] elig, cand;

    always_comb begin
        elig = irr & ~imr;
        if (smm)
            cand = elig & ~isr;
        else
            cand = elig & pass_mask(isr, nest);
        win = pick_lowest(cand);
        irq = |cand;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr_odd,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [NL-1:0] req_in,
    output logic          irq_out,
    input  logic          ack_in,
    input  logic [LW-1:0] cas_in,
    output logic [LW-1:0] cas_out,
    output logic          cas_oe
);

    ctrl_cfg_t     cfg;
    logic [NL-1:0] imr, irr, isr;
    logic          sel_isr, smm, poll_req, eoi_ns, eoi_sp, init_clr;
    logic [LW-1:0] eoi_line;
    pick_t         win;
    logic          irq_int;

    logic          ack_ph, poll_pend;
    logic [LW-1:0] ack_line;
    logic          slave_role, ack_hit, ack_first, ack_second, poll_take;
    logic          slave_line;
    logic [NL-1:0] isr_set, isr_clr;
    pick_t         isr_top;

    irq_cmd_decode u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_odd(addr_odd),
        .wr_data(wr_data), .cfg(cfg), .imr(imr), .sel_isr(sel_isr),
        .smm(smm), .poll_req(poll_req), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp),
        .eoi_line(eoi_line), .init_clr(init_clr)
    );

    irq_req_capture u_cap (
        .clk(clk), .rst(rst), .level_mode(cfg.level_mode), .flush(init_clr),
        .req_in(req_in), .clr_lines(isr_set), .irr(irr)
    );

    irq_prio_resolve u_res (
        .irr(irr), .isr(isr), .imr(imr), .nest(cfg.sfnm), .smm(smm),
        .irq(irq_int), .win(win)
    );

    assign slave_role = ~cfg.single_mode & ~cfg.master;
    assign ack_hit    = ack_in & (~slave_role | (cas_in == cfg.cas_word[LW-1:0]));
    assign ack_first  = ack_hit & ~ack_ph;
    assign ack_second = ack_hit & ack_ph;
    assign poll_take  = rd_en & ~addr_odd & poll_pend & ~ack_in;
    assign slave_line = ~cfg.single_mode & cfg.master & cfg.cas_word[ack_line];

    always_comb begin
        isr_set = '0;
        if ((ack_first || poll_take) && win.valid)
            isr_set = onehot(win.idx);
        isr_top = pick_lowest(isr);
        isr_clr = '0;
        if (eoi_ns && isr_top.valid) isr_clr = isr_clr | onehot(isr_top.idx);
        if (eoi_sp) isr_clr = isr_clr | onehot(eoi_line);
        if (ack_second && cfg.aeoi) isr_clr = isr_clr | onehot(ack_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            ack_ph    <= 1'b0;
            ack_line  <= '0;
            poll_pend <= 1'b0;
        end else if (init_clr) begin
            isr       <= '0;
            ack_ph    <= 1'b0;
            poll_pend <= 1'b0;
        end else begin
            isr <= (isr | isr_set) & ~isr_clr;
            if (ack_first) begin
                ack_ph   <= 1'b1;
                ack_line <= win.valid ? win.idx : LW'(NL - 1);
            end else if (ack_second) begin
                ack_ph <= 1'b0;
            end
            if (poll_req)
                poll_pend <= 1'b1;
            else if (poll_take)
                poll_pend <= 1'b0;
        end
    end

    assign irq_out = irq_int;
    assign cas_oe  = ack_ph & slave_line;
    assign cas_out = cas_oe ? ack_line : '0;

    always_comb begin
        if (ack_in)
            rd_data = (ack_second && !slave_line) ?
                      cfg.vec_base + DW'(ack_line) : '0;
        else if (addr_odd)
            rd_data = imr;
        else if (poll_pend)
            rd_data = {win.valid, {(DW-LW-1){1'b0}}, win.idx};
        else
            rd_data = sel_isr ? isr : irr;
    end

    AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_first && win.valid && !wr_en) |=> isr[$past(win.idx)]); // R8

    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (|(irr & ~imr))); // R3

    AST_AEOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_second && cfg.aeoi && !wr_en) |=> !isr[$past(ack_line)]); // R9

    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (rst)
        eoi_sp |=> !isr[$past(eoi_line)]); // R10

    AST_SLAVE_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (slave_role && ack_in && cas_in != cfg.cas_word[LW-1:0] && !wr_en && !rd_en)
        |=> $stable(isr)); // R14

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst, wr_en, rd_en, addr_odd, ack_in, irq_out, cas_oe;
    logic [7:0] wr_data, rd_data, req_in;
    logic [2:0] cas_in, cas_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_irr, m_isr, m_imr, m_prev;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
        .wr_data(wr_data), .rd_data(rd_data), .req_in(req_in), .irq_out(irq_out),
        .ack_in(ack_in), .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_irr  = m_irr | (req_in & ~m_prev);
        m_prev = req_in;
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr_odd = a; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr_odd = a;
        #1;
        v = rd_data;
    endtask

    task automatic ack_pair(output logic [7:0] vec, output logic oe, output logic [2:0] co);
        ack_in = 1'b1;
        step();
        #1;
        vec = rd_data; oe = cas_oe; co = cas_out;
        step();
        ack_in = 1'b0;
    endtask

    function automatic logic [3:0] exp_pick(input logic [7:0] irr, input logic [7:0] isr,
                                            input logic [7:0] imr);
        int barrier;
        barrier = 8;
        for (int i = 7; i >= 0; i--) if (isr[i]) barrier = i;
        for (int i = 0; i < 8; i++)
            if (i < barrier && irr[i] && !imr[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       oe;
        logic [2:0] co;
        logic [3:0] p;
        logic [7:0] mk;
        void'($urandom(32'd4711));
        m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0;
        rst = 1; wr_en = 0; rd_en = 0; addr_odd = 0; ack_in = 0;
        wr_data = 0; req_in = 0; cas_in = 0;
        repeat (3) step();
        rst = 0;
        step();

        rd(1, v); chk("R2 mask after reset", v, 8'hFF);
        rd(0, v); chk("R2 pending after reset", v, 8'h00);
        chk("R2 irq after reset", irq_out, 0);

        // single, edge, last word announced: no cascade word expected
        wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'hF0);
        rd(1, v); chk("R1 single mode skips cascade word", v, 8'hF0);

        req_in = 8'h01; step(); step();
        rd(0, v); chk("R11 edge latched", v, 8'h01);
        chk("R5 irq line0", irq_out, 1);
        wr(1, 8'hF1);
        chk("R3 masked line no irq", irq_out, 0);
        rd(0, v); chk("R3 masked line still pending", v, 8'h01);
        wr(1, 8'h00);
        chk("R3 unmask raises irq", irq_out, 1);

        req_in = 8'h05; step();
        ack_pair(v, oe, co); chk("R8 vector line0", v, 8'h20);
        wr(0, 8'h0B); rd(0, v); chk("R4 read isr", v, 8'h01);
        chk("R5 lower line blocked", irq_out, 0);
        wr(0, 8'h0A); req_in = 8'h00; step();
        rd(0, v); chk("R11 edge held after input drop", v, 8'h04);
        wr(0, 8'h20);
        wr(0, 8'h0B); rd(0, v); chk("R10 non-specific eoi", v, 8'h00);
        wr(0, 8'h0A);
        chk("R5 line2 after eoi", irq_out, 1);
        ack_pair(v, oe, co); chk("R8 vector line2", v, 8'h22);
        req_in = 8'h02; step();
        chk("R5 higher line preempts", irq_out, 1);
        ack_pair(v, oe, co); chk("R8 vector line1", v, 8'h21);
        req_in = 8'h08; step();
        chk("R5 line3 blocked", irq_out, 0);
        wr(0, 8'h62);
        wr(0, 8'h0B); rd(0, v); chk("R10 specific eoi line2", v, 8'h02);
        wr(0, 8'h02); rd(0, v); chk("R10 eoi flag clear ignored", v, 8'h02);
        wr(0, 8'h20); rd(0, v); chk("R10 non-specific clears line1", v, 8'h00);
        wr(0, 8'h0A);
        ack_pair(v, oe, co); chk("R8 vector line3", v, 8'h23);
        wr(0, 8'h20);
        chk("R8 no request no irq", irq_out, 0);
        ack_pair(v, oe, co); chk("R8 spurious vector", v, 8'h27);
        wr(0, 8'h0B); rd(0, v); chk("R8 spurious sets no isr", v, 8'h00);
        wr(0, 8'h0A);

        req_in = 8'h09; step();
        ack_pair(v, oe, co); chk("R8 vector line0 again", v, 8'h20);
        req_in = 8'h01; step(); req_in = 8'h09; step();
        chk("R7 blocked before special mask", irq_out, 0);
        wr(0, 8'h68); chk("R7 special mask admits line3", irq_out, 1);
        wr(0, 8'h48); chk("R7 special mask left", irq_out, 0);
        wr(0, 8'h20);
        ack_pair(v, oe, co); chk("R8 vector line3 after smm", v, 8'h23);
        wr(0, 8'h20);
        req_in = 8'h00; step();

        // random phase, fresh setup
        wr(0, 8'h13); m_irr = 0; m_isr = 0; m_imr = 8'hFF;
        wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h00); m_imr = 8'h00;
        for (int k = 0; k < 80; k++) begin
            req_in = 8'($urandom);
            step();
            if ($urandom % 4 == 0) begin
                mk = 8'($urandom) & 8'($urandom);
                wr(1, mk); m_imr = mk;
            end
            rd(0, v); chk("R11 random pending", v, m_irr);
            p = exp_pick(m_irr, m_isr, m_imr);
            chk("R5 random irq", irq_out, p[3]);
            if (p[3] && ($urandom % 2 == 0)) begin
                ack_pair(v, oe, co);
                chk("R8 random vector", v, 8'h20 + p[2:0]);
                m_isr = m_isr | (8'h01 << p[2:0]);
                m_irr = m_irr & ~(8'h01 << p[2:0]);
            end else if (m_isr != 0 && ($urandom % 3 == 0)) begin
                wr(0, 8'h20);
                m_isr = m_isr & (m_isr - 8'h01);
            end
        end
        req_in = 8'h00; step();

        // level capture with automatic end of interrupt
        req_in = 8'h10;
        wr(0, 8'h0B);
        wr(0, 8'h1B);
        rd(1, v); chk("R2 setup start masks all", v, 8'hFF);
        wr(1, 8'h40); wr(1, 8'h02);
        rd(0, v); chk("R2 read select back to pending", v, 8'h10);
        wr(1, 8'h00);
        chk("R11 level request irq", irq_out, 1);
        req_in = 8'h00; step();
        rd(0, v); chk("R11 level follows input", v, 8'h00);
        chk("R11 level drop no irq", irq_out, 0);
        req_in = 8'h10; step();
        ack_pair(v, oe, co); chk("R8 level vector", v, 8'h44);
        wr(0, 8'h0B); rd(0, v); chk("R9 auto eoi clears isr", v, 8'h00);
        req_in = 8'h00; step();

        // cascade master, nested mode
        wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h04); wr(1, 8'h10); wr(1, 8'h00);
        rd(1, v); chk("R1 cascade takes cascade word", v, 8'h00);
        req_in = 8'h04; step();
        ack_pair(v, oe, co);
        chk("R13 master leaves vector to slave", v, 8'h00);
        chk("R13 cascade enable", oe, 1);
        chk("R13 cascade line", co, 3'd2);
        req_in = 8'h00; step(); req_in = 8'h04; step();
        chk("R6 nested readmits same line", irq_out, 1);
        ack_pair(v, oe, co);
        wr(0, 8'h20);
        req_in = 8'h08; step();
        ack_pair(v, oe, co);
        chk("R13 no cascade for plain line", oe, 0);
        chk("R13 plain line vector", v, 8'h0B);
        wr(0, 8'h20);
        req_in = 8'h00; step();

        // cascade slave with identity 5
        wr(0, 8'h11); wr(1, 8'h70); wr(1, 8'h05); wr(1, 8'h08); wr(1, 8'h00);
        req_in = 8'h02; step();
        cas_in = 3'd3; ack_in = 1'b1; step(); ack_in = 1'b0;
        wr(0, 8'h0B); rd(0, v); chk("R14 foreign identity ignored isr", v, 8'h00);
        wr(0, 8'h0A); rd(0, v); chk("R14 foreign identity keeps pending", v, 8'h02);
        cas_in = 3'd5;
        ack_pair(v, oe, co); chk("R14 matching identity vector", v, 8'h71);
        wr(0, 8'h20);

        // poll
        req_in = 8'h42; step();
        wr(0, 8'h0C);
        addr_odd = 0; rd_en = 1'b1; #1; v = rd_data;
        chk("R12 poll word", v, 8'h86);
        step(); rd_en = 1'b0;
        wr(0, 8'h0B); rd(0, v); chk("R12 poll takes line into service", v, 8'h40);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule